// File: doc/BRIEF.md
# Windowed Watchdog Fault Supervisor

This block keeps the fault accounting for a windowed watchdog. Each refresh it receives has already been judged good or bad. Good refreshes advance a refresh counter toward a configurable limit. A good refresh that arrives while that counter sits at its limit winds a fault counter down by one. A bad refresh clears the refresh counter and pushes the fault counter up by one. The fault counter stops rising at its configured limit.

While the fault counter is at or above its limit, the block holds a fail-safe output high. On the refresh that brings the counter to the limit, it also raises a reset request for a programmable number of cycles. After power-up the block is in an initialization phase, during which the configuration register accepts writes. The first good refresh ends this phase and locks the configuration. A self-test timer then starts, and when it expires it sets a pass flag.

Software sees the block through a small register port. It can read the refresh count, the refresh limit and the fault count, and from these work out how many good refreshes remain. The event flags are cleared by writing a one to them.

Top module: `wdfc_top`

## Requirements
- R1: After reset the refresh count is 5 (the default limit 6 minus one) and the fault count is 1. The configuration reads 0x0846. Fail-safe, reset request, self-test busy and all flags are 0, and the init-phase output is 1.
- R2: A good refresh with the refresh count below the refresh limit raises the refresh count by one and leaves the fault count unchanged.
- R3: A good refresh with the refresh count at or above the limit returns the refresh count to 0 and lowers a nonzero fault count by one. After reset, exactly two good refreshes bring the fault count to 0.
- R4: A bad refresh returns the refresh count to 0 and raises the fault count by one. The fault count never rises past the fault limit.
- R5: Fail-safe is high while the fault count is at or above the fault limit. The refresh that brings the count to the limit raises the reset request on the next edge, and it stays high for exactly the programmed pulse length in cycles.
- R6: Only a good refresh ends the initialization phase. The configuration register at address 0 (bits 2:0 refresh limit, 6:4 fault limit, 15:8 pulse length) takes writes during the phase and ignores them after it.
- R7: When the phase ends, self-test busy is high for ST_CYCLES cycles (default 12). Flag bit 2 is set on the edge where busy drops.
- R8: The flags at address 2 are bit 0 (bad refresh seen), bit 1 (fault limit reached) and bit 2 (self-test pass). Writing a one clears a flag, and a set event in the same cycle wins over the clear.
- R9: The status register at address 1 holds the refresh count in bits 2:0, the refresh limit in bits 6:4 and the fault count in bits 10:8. It is read-only, so a write to it changes nothing. Reads return the selected register one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_refresh | input | 1 | A classified refresh event occurs this cycle |
| wd_good | input | 1 | The refresh event is good (1) or bad (0) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for reg_addr |
| fail_safe_o | output | 1 | Fault count at or above the fault limit |
| reset_req_o | output | 1 | Reset request pulse |
| init_phase_o | output | 1 | Initialization phase open |
| selftest_busy_o | output | 1 | Self-test timer running |

## Verification
The hardest state to reach is a reset-request pulse that the bench can measure while configuration is still writable. Closing the init phase takes a good refresh, so shortening the pulse and lowering the fault limit must happen before any good refresh is sent. The bench therefore resets, sets the fault limit to 2 and the pulse length to 5, and then sends one bad refresh to hit the limit from the power-up count of 1. In the same cycle it writes a clear to the bad-refresh flag, to show that a set event wins over the clear. A long vector table then drives the count up to saturation, interrupts a refresh streak with a bad refresh, and winds the count back down.

// File: rtl/wdfc_pkg.sv
package wdfc_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 2;

  localparam logic [AW-1:0] A_CFG  = 2'd0;
  localparam logic [AW-1:0] A_STAT = 2'd1;
  localparam logic [AW-1:0] A_FLAG = 2'd2;

  localparam int unsigned F_BAD    = 0;
  localparam int unsigned F_LIMIT  = 1;
  localparam int unsigned F_STPASS = 2;
  localparam int unsigned NFLAG    = 3;

  localparam int unsigned CFG_RLIM_LSB  = 0;
  localparam int unsigned CFG_FLIM_LSB  = 4;
  localparam int unsigned CFG_PULSE_LSB = 8;

  localparam int unsigned ST_RCNT_LSB = 0;
  localparam int unsigned ST_RLIM_LSB = 4;
  localparam int unsigned ST_FCNT_LSB = 8;

  typedef struct packed {
    logic vld;
    logic good;
  } wd_evt_t;
endpackage

// File: rtl/wdfc_counters.sv
module wdfc_counters
  import wdfc_pkg::*;
#(
  parameter int unsigned RCW      = 3,
  parameter int unsigned FCW      = 3,
  parameter int unsigned PW       = 8,
  parameter int unsigned RLIM_DEF = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  wd_evt_t        evt,
  input  logic [RCW-1:0] rlim,
  input  logic [FCW-1:0] flim,
  input  logic [PW-1:0]  pulse_len,
  output logic [RCW-1:0] rcnt_o,
  output logic [FCW-1:0] fcnt_o,
  output logic           fail_safe_o,
  output logic           reset_req_o,
  output logic           limit_hit_o
);
  localparam logic [RCW-1:0] RCNT_RST = RCW'(RLIM_DEF - 1);
  localparam logic [FCW-1:0] FCNT_RST = FCW'(1);

  logic [RCW-1:0] rcnt_q, rcnt_d;
  logic [FCW-1:0] fcnt_q, fcnt_d;
  logic [PW-1:0]  pulse_q;
  logic           fs_q;
  logic           hit;

  always_comb begin
    rcnt_d = rcnt_q;
    fcnt_d = fcnt_q;
    if (evt.vld) begin
      if (evt.good) begin
        if (rcnt_q >= rlim) begin
          rcnt_d = '0;
          if (fcnt_q != '0) fcnt_d = fcnt_q - 1'b1;
        end else begin
          rcnt_d = rcnt_q + 1'b1;
        end
      end else begin
        rcnt_d = '0;
        if (fcnt_q < flim) fcnt_d = fcnt_q + 1'b1;
      end
    end
  end

  assign hit = evt.vld && !evt.good && (fcnt_q < flim) && (fcnt_d >= flim);

  always_ff @(posedge clk) begin
    if (rst) begin
      rcnt_q  <= RCNT_RST;
      fcnt_q  <= FCNT_RST;
      pulse_q <= '0;
      fs_q    <= 1'b0;
    end else begin
      rcnt_q <= rcnt_d;
      fcnt_q <= fcnt_d;
      fs_q   <= (fcnt_d >= flim);
      if (hit)
        pulse_q <= pulse_len;
      else if (pulse_q != '0)
        pulse_q <= pulse_q - 1'b1;
    end
  end

  assign rcnt_o      = rcnt_q;
  assign fcnt_o      = fcnt_q;
  assign fail_safe_o = fs_q;
  assign reset_req_o = (pulse_q != '0);
  assign limit_hit_o = hit;

  // R2
  good_step_chk: assert property (@(posedge clk) disable iff (rst)
    (evt.vld && evt.good && rcnt_q < rlim) |=> (rcnt_q == $past(rcnt_q) + 1'b1));

  // R3
  wind_down_chk: assert property (@(posedge clk) disable iff (rst)
    (evt.vld && evt.good && rcnt_q >= rlim && fcnt_q != '0)
      |=> (rcnt_q == '0 && fcnt_q == $past(fcnt_q) - 1'b1));

  // R4
  bad_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (evt.vld && !evt.good) |=> (rcnt_q == '0));

  // R5
  pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && pulse_len != '0) |=> (reset_req_o && fail_safe_o));
endmodule

// File: rtl/wdfc_phase.sv
module wdfc_phase
  import wdfc_pkg::*;
#(
  parameter int unsigned ST_CYCLES = 12
) (
  input  logic    clk,
  input  logic    rst,
  input  wd_evt_t evt,
  output logic    init_open_o,
  output logic    st_busy_o,
  output logic    st_pass_o
);
  localparam int unsigned STW = $clog2(ST_CYCLES + 1);
  localparam logic [STW-1:0] ST_LOAD = STW'(ST_CYCLES);

  logic           init_q;
  logic [STW-1:0] st_q;
  logic           close;

  assign close = init_q && evt.vld && evt.good;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= 1'b1;
      st_q   <= '0;
    end else begin
      if (close) init_q <= 1'b0;
      if (close)
        st_q <= ST_LOAD;
      else if (st_q != '0)
        st_q <= st_q - 1'b1;
    end
  end

  assign init_open_o = init_q;
  assign st_busy_o   = (st_q != '0);
  assign st_pass_o   = (st_q == STW'(1));

  // R7
  busy_after_init_chk: assert property (@(posedge clk) disable iff (rst)
    st_busy_o |-> !init_open_o);

  // R7
  start_on_close_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(init_open_o) |-> st_busy_o);
endmodule

// File: rtl/wdfc_regs.sv
module wdfc_regs
  import wdfc_pkg::*;
#(
  parameter int unsigned RCW       = 3,
  parameter int unsigned FCW       = 3,
  parameter int unsigned PW        = 8,
  parameter int unsigned RLIM_DEF  = 6,
  parameter int unsigned FLIM_DEF  = 4,
  parameter int unsigned PULSE_DEF = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  wd_evt_t        evt,
  input  logic           limit_hit,
  input  logic           st_pass,
  input  logic           init_open,
  input  logic [RCW-1:0] rcnt,
  input  logic [FCW-1:0] fcnt,
  output logic [RCW-1:0] rlim_o,
  output logic [FCW-1:0] flim_o,
  output logic [PW-1:0]  pulse_o,
  output logic [DW-1:0]  rdata_o
);
  logic [RCW-1:0]   rlim_q;
  logic [FCW-1:0]   flim_q;
  logic [PW-1:0]    pulse_q;
  logic [NFLAG-1:0] flags_q, set_v, clr_v;
  logic [DW-1:0]    rd_d, rd_q;
  logic             cfg_we;

  assign cfg_we = wr && init_open && (addr == A_CFG);

  always_comb begin
    set_v           = '0;
    set_v[F_BAD]    = evt.vld && !evt.good;
    set_v[F_LIMIT]  = limit_hit;
    set_v[F_STPASS] = st_pass;
    clr_v = (wr && addr == A_FLAG) ? wdata[NFLAG-1:0] : '0;
  end

  always_comb begin
    rd_d = '0;
    case (addr)
      A_CFG: begin
        rd_d[CFG_RLIM_LSB  +: RCW] = rlim_q;
        rd_d[CFG_FLIM_LSB  +: FCW] = flim_q;
        rd_d[CFG_PULSE_LSB +: PW]  = pulse_q;
      end
      A_STAT: begin
        rd_d[ST_RCNT_LSB +: RCW] = rcnt;
        rd_d[ST_RLIM_LSB +: RCW] = rlim_q;
        rd_d[ST_FCNT_LSB +: FCW] = fcnt;
      end
      A_FLAG:  rd_d[NFLAG-1:0] = flags_q;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rlim_q  <= RCW'(RLIM_DEF);
      flim_q  <= FCW'(FLIM_DEF);
      pulse_q <= PW'(PULSE_DEF);
      flags_q <= '0;
      rd_q    <= '0;
    end else begin
      if (cfg_we) begin
        rlim_q  <= wdata[CFG_RLIM_LSB  +: RCW];
        flim_q  <= wdata[CFG_FLIM_LSB  +: FCW];
        pulse_q <= wdata[CFG_PULSE_LSB +: PW];
      end
      flags_q <= (flags_q & ~clr_v) | set_v;
      rd_q    <= rd_d;
    end
  end

  assign rlim_o  = rlim_q;
  assign flim_o  = flim_q;
  assign pulse_o = pulse_q;
  assign rdata_o = rd_q;

  // R6
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (!init_open && wr && addr == A_CFG)
      |=> ($stable(rlim_q) && $stable(flim_q) && $stable(pulse_q)));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_v != '0) |=> ((flags_q & $past(set_v)) == $past(set_v)));
endmodule

// File: rtl/wdfc_top.sv
module wdfc_top
  import wdfc_pkg::*;
#(
  parameter int unsigned RCW       = 3,
  parameter int unsigned FCW       = 3,
  parameter int unsigned PW        = 8,
  parameter int unsigned RLIM_DEF  = 6,
  parameter int unsigned FLIM_DEF  = 4,
  parameter int unsigned PULSE_DEF = 8,
  parameter int unsigned ST_CYCLES = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wd_refresh,
  input  logic        wd_good,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        fail_safe_o,
  output logic        reset_req_o,
  output logic        init_phase_o,
  output logic        selftest_busy_o
);
  wd_evt_t        evt;
  logic [RCW-1:0] rlim, rcnt;
  logic [FCW-1:0] flim, fcnt;
  logic [PW-1:0]  pulse_len;
  logic           limit_hit, st_pass, init_open;

  assign evt.vld  = wd_refresh;
  assign evt.good = wd_good;

  wdfc_counters #(
    .RCW(RCW), .FCW(FCW), .PW(PW), .RLIM_DEF(RLIM_DEF)
  ) u_cnt (
    .clk(clk), .rst(rst), .evt(evt),
    .rlim(rlim), .flim(flim), .pulse_len(pulse_len),
    .rcnt_o(rcnt), .fcnt_o(fcnt),
    .fail_safe_o(fail_safe_o), .reset_req_o(reset_req_o),
    .limit_hit_o(limit_hit)
  );

  wdfc_phase #(.ST_CYCLES(ST_CYCLES)) u_phase (
    .clk(clk), .rst(rst), .evt(evt),
    .init_open_o(init_open), .st_busy_o(selftest_busy_o),
    .st_pass_o(st_pass)
  );

  wdfc_regs #(
    .RCW(RCW), .FCW(FCW), .PW(PW),
    .RLIM_DEF(RLIM_DEF), .FLIM_DEF(FLIM_DEF), .PULSE_DEF(PULSE_DEF)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .evt(evt), .limit_hit(limit_hit), .st_pass(st_pass),
    .init_open(init_open), .rcnt(rcnt), .fcnt(fcnt),
    .rlim_o(rlim), .flim_o(flim), .pulse_o(pulse_len),
    .rdata_o(reg_rdata)
  );

  assign init_phase_o = init_open;
endmodule

// File: tb/tb_wdfc_top.sv
`timescale 1ns/1ps
module tb_wdfc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wd_refresh = 1'b0, wd_good = 1'b0, reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        fail_safe_o, reset_req_o, init_phase_o, selftest_busy_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdfc_top dut (
    .clk(clk), .rst(rst), .wd_refresh(wd_refresh), .wd_good(wd_good),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fail_safe_o(fail_safe_o),
    .reset_req_o(reset_req_o), .init_phase_o(init_phase_o),
    .selftest_busy_o(selftest_busy_o)
  );

  // Vector: {good, exp refresh count[2:0], exp fault count[2:0], exp fail-safe}
  localparam int NV = 24;
  localparam logic [7:0] VEC [NV] = '{
    8'b0_000_001_0, 8'b1_001_001_0, 8'b1_010_001_0, 8'b1_011_001_0,
    8'b1_100_001_0, 8'b1_101_001_0, 8'b1_110_001_0, 8'b1_000_000_0,
    8'b0_000_001_0, 8'b0_000_010_0, 8'b0_000_011_0, 8'b0_000_100_1,
    8'b0_000_100_1, 8'b1_001_100_1, 8'b1_010_100_1, 8'b0_000_100_1,
    8'b1_001_100_1, 8'b1_010_100_1, 8'b1_011_100_1, 8'b1_100_100_1,
    8'b1_101_100_1, 8'b1_110_100_1, 8'b1_000_011_0, 8'b1_001_011_0
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic refresh(input bit g);
    @(negedge clk); wd_refresh = 1'b1; wd_good = g;
    @(negedge clk); wd_refresh = 1'b0; wd_good = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  function automatic logic [15:0] stat(input int r, input int l, input int f);
    return 16'((f << 8) | (l << 4) | r);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int cnt;
    do_reset();
    // R1 reset state
    rd(2'd1, v); chk(v == stat(5, 6, 1), "R1 status", v, stat(5, 6, 1));
    rd(2'd0, v); chk(v == 16'h0846, "R1 cfg", v, 16'h0846);
    rd(2'd2, v); chk(v == 16'h0, "R1 flags", v, 0);
    chk({fail_safe_o, reset_req_o, init_phase_o, selftest_busy_o} == 4'b0010,
        "R1 outputs", {fail_safe_o, reset_req_o, init_phase_o, selftest_busy_o}, 4'b0010);
    // R9 status write ignored, fault field read-only
    wr(2'd1, 16'hFFFF);
    rd(2'd1, v); chk(v == stat(5, 6, 1), "R9 status write ignored", v, stat(5, 6, 1));

    // R6/R7 first good refresh closes init, self-test runs
    refresh(1'b1);
    chk(init_phase_o == 1'b0, "R6 init closed", init_phase_o, 0);
    cnt = 0;
    repeat (20) begin
      if (selftest_busy_o) cnt++;
      @(negedge clk);
    end
    chk(cnt == 12, "R7 busy length", cnt, 12);
    rd(2'd2, v); chk(v == 16'h4, "R7 pass flag", v, 16'h4);
    rd(2'd1, v); chk(v == stat(6, 6, 1), "R2 first good", v, stat(6, 6, 1));
    refresh(1'b1);
    rd(2'd1, v); chk(v == stat(0, 6, 0), "R3 two goods clear fault", v, stat(0, 6, 0));
    // R6 lock after close
    wr(2'd0, 16'h0111);
    rd(2'd0, v); chk(v == 16'h0846, "R6 cfg locked", v, 16'h0846);
    // R8 write one to clear
    wr(2'd2, 16'h0004);
    rd(2'd2, v); chk(v == 16'h0, "R8 w1c", v, 0);

    // Table walk: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      refresh(VEC[i][7]);
      chk(fail_safe_o == VEC[i][0], "R5 fail-safe", fail_safe_o, VEC[i][0]);
      rd(2'd1, v);
      chk(v == stat(int'(VEC[i][6:4]), 6, int'(VEC[i][3:1])),
          VEC[i][7] ? "R2/R3 good step" : "R4 bad step",
          v, stat(int'(VEC[i][6:4]), 6, int'(VEC[i][3:1])));
    end

    // R5 pulse length with configured limit and pulse, R8 set wins
    do_reset();
    wr(2'd0, 16'h0526);
    rd(2'd0, v); chk(v == 16'h0526, "R6 cfg write in init", v, 16'h0526);
    @(negedge clk);
    wd_refresh = 1'b1; wd_good = 1'b0;
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0001;
    @(negedge clk);
    wd_refresh = 1'b0; reg_wr = 1'b0;
    chk(fail_safe_o == 1'b1, "R5 fail-safe at limit", fail_safe_o, 1);
    cnt = 0;
    repeat (12) begin
      if (reset_req_o) cnt++;
      @(negedge clk);
    end
    chk(cnt == 5, "R5 pulse length", cnt, 5);
    chk(init_phase_o == 1'b1, "R6 bad refresh keeps init", init_phase_o, 1);
    rd(2'd2, v); chk(v == 16'h3, "R8 set wins over clear", v, 16'h3);
    wr(2'd2, 16'h0002);
    rd(2'd2, v); chk(v == 16'h1, "R8 selective clear", v, 16'h1);
    refresh(1'b0);
    rd(2'd1, v); chk(v == stat(0, 6, 2), "R4 saturate at limit", v, stat(0, 6, 2));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule